// File: doc/BRIEF.md
# Variable-latency speculative carry adder

This block adds two N-bit two's-complement operands and always returns the exact sum and carry-out. The datapath is cut into equal groups of K bits. For almost every operand pair, the fast path finishes the add in one cycle. In that path, the carry into each group comes only from the group directly beneath it, and that lower group is assumed to receive no carry of its own. A carry therefore never crosses more than two groups in this path.

A mode detector looks at the operands in the stage ahead of the add, in the same cycle they are handed over. The detector looks for the one situation the fast path gets wrong: a group whose bits all propagate while a real carry enters it. When it finds that situation, it marks the pair for the slow path. The slow path ripples the exact carry through one group per cycle, starting at bit 0. While a slow add runs, the block stops accepting new operands. The result comes back with a done pulse and a flag that reports which path produced it.

Top module: `spec_adder`

## Requirements
- R1: For every accepted pair, the reported `out_sum` equals (`in_a` + `in_b`) mod 2^N and `out_cout` equals bit N of the full sum, whichever path is used.
- R2: A fast-path pair accepted at clock edge E raises `out_done` for one cycle after edge E+1, with `out_slow` = 0.
- R3: `out_slow` is 1 exactly when there is a group m, with 1 <= m <= N/K-2, such that the true carry into bit m*K is 1 and every bit of `in_a ^ in_b` in bits m*K to m*K+K-1 is 1. Group m covers those bits. Otherwise `out_slow` is 0.
- R4: A slow-path pair accepted at edge E raises `out_done` for one cycle after edge E+N/K, with `out_slow` = 1.
- R5: `in_ready` is 0 from the cycle after a slow-path pair is accepted until `out_done` for that pair rises. In that cycle `in_ready` returns to 1.
- R6: A top group whose bits all propagate and which receives a carry from the group below stays on the fast path. Its carry reaches `out_cout`.
- R7: When only fast-path pairs arrive, `in_ready` stays 1 and a new pair is accepted every cycle. Results appear in order of acceptance, one per cycle.
- R8: During and right after a synchronous reset, `out_done`, `out_sum`, `out_cout` and `out_slow` are 0 and `in_ready` is 1. Any add in flight is dropped.
- R9: No `out_done` pulse appears unless an accepted pair is completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | N | First operand |
| in_b | input | N | Second operand |
| out_done | output | 1 | One-cycle pulse when a result is presented |
| out_sum | output | N | Exact sum, held until the next result |
| out_cout | output | 1 | Carry out of bit N-1 |
| out_slow | output | 1 | 1 when the result came from the multi-cycle path |

## Verification
Suppose the detector makes a wrong decision and sends a pair down the fast path when the slow path was needed. The sum is then wrong by a carry in one group, and that error shows on `out_sum` two cycles after acceptance. The opposite mistake shows only in timing: `out_slow` and the N/K+1 cycle latency appear where 2 cycles were expected. If the group index or the carry register in the ripple engine is corrupt, the error stays hidden until the top group resolves. It then shows up as a wrong slice of the sum, a wrong carry-out, or a done pulse at the wrong time. A stuck busy state shows up at once as `in_ready` held at 0.

// File: rtl/spadd_pkg.sv
package spadd_pkg;

    typedef enum logic {
        MODE_FAST = 1'b0,
        MODE_EXT  = 1'b1
    } add_mode_e;

    // number of carry groups for a given width and group size
    function automatic int unsigned group_count(int unsigned width, int unsigned gsz);
        return width / gsz;
    endfunction

endpackage

// File: rtl/spadd_mode_detect.sv
// Decides, one stage ahead of the add, whether the two-group carry window
// is enough. Only the lower N-K bits matter: the top group may propagate freely.
module spadd_mode_detect
    import spadd_pkg::*;
#(
    parameter int unsigned N = 32,
    parameter int unsigned K = 8
) (
    input  logic [N-K-1:0] op_a,
    input  logic [N-K-1:0] op_b,
    output add_mode_e      mode
);
    localparam int unsigned G = group_count(N, K);

    logic [G-2:0] gen;
    logic [G-1:0] hit;

    // group generate with zero carry-in: the K-bit sum wraps
    for (genvar g = 0; g < G - 1; g++) begin : g_gen
        logic [K-1:0] sa;
        logic [K-1:0] sb;
        assign sa     = op_a[g*K +: K];
        assign sb     = op_b[g*K +: K];
        assign gen[g] = (sa + sb) < sa;
    end

    // a fully propagating middle group fed by a generating group below it
    for (genvar m = 0; m < G; m++) begin : g_hit
        if (m >= 1 && m <= G - 2) begin : g_mid
            assign hit[m] = (&(op_a[m*K +: K] ^ op_b[m*K +: K])) & gen[m-1];
        end else begin : g_edge
            assign hit[m] = 1'b0;
        end
    end

    assign mode = (|hit) ? MODE_EXT : MODE_FAST;

endmodule

// File: rtl/spadd_spec_sum.sv
// One-cycle speculative sum: each group's carry-in is the lower group's
// carry-out computed as if that group had no carry-in.
module spadd_spec_sum #(
    parameter int unsigned N = 32,
    parameter int unsigned K = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int unsigned G = spadd_pkg::group_count(N, K);

    logic [G-2:0] gen;

    for (genvar g = 0; g < G; g++) begin : g_grp
        logic [K-1:0] sa;
        logic [K-1:0] sb;
        assign sa = a[g*K +: K];
        assign sb = b[g*K +: K];

        if (g < G - 1) begin : g_lowgen
            assign gen[g] = (sa + sb) < sa;
        end

        if (g == 0) begin : g_bottom
            assign sum[K-1:0] = sa + sb;
        end else if (g == G - 1) begin : g_top
            assign {cout, sum[g*K +: K]} = {1'b0, sa} + {1'b0, sb} + {{K{1'b0}}, gen[g-1]};
        end else begin : g_mid
            assign sum[g*K +: K] = sa + sb + {{(K-1){1'b0}}, gen[g-1]};
        end
    end

endmodule

// File: rtl/spadd_ext_engine.sv
// Exact multi-cycle path: resolves one group per clock, bit 0 upward.
// Group 0 is resolved on the start edge from the start operands.
module spadd_ext_engine #(
    parameter int unsigned N = 32,
    parameter int unsigned K = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] st_a,
    input  logic [N-1:0] st_b,
    output logic         busy,
    output logic         fin,
    output logic [N-1:0] fin_sum,
    output logic         fin_cout
);
    localparam int unsigned G  = spadd_pkg::group_count(N, K);
    localparam int unsigned GW = (G > 1) ? $clog2(G) : 1;
    localparam logic [GW-1:0] LAST = GW'(G - 1);

    logic [N-1:0]  a_r, b_r, part_r;
    logic [GW-1:0] idx_r;
    logic          cy_r;

    logic [K-1:0] cur_a, cur_b, grp_s;
    logic         cur_c, grp_co;

    always_comb begin
        if (busy) begin
            cur_a = a_r[idx_r*K +: K];
            cur_b = b_r[idx_r*K +: K];
            cur_c = cy_r;
        end else begin
            cur_a = st_a[K-1:0];
            cur_b = st_b[K-1:0];
            cur_c = 1'b0;
        end
        {grp_co, grp_s} = {1'b0, cur_a} + {1'b0, cur_b} + {{K{1'b0}}, cur_c};
    end

    assign fin      = busy && (idx_r == LAST);
    assign fin_cout = grp_co;

    always_comb begin
        fin_sum          = part_r;
        fin_sum[N-1 -: K] = grp_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx_r  <= '0;
            cy_r   <= 1'b0;
            a_r    <= '0;
            b_r    <= '0;
            part_r <= '0;
        end else if (!busy && start) begin
            a_r           <= st_a;
            b_r           <= st_b;
            part_r        <= '0;
            part_r[K-1:0] <= grp_s;
            cy_r          <= grp_co;
            idx_r         <= GW'(1);
            busy          <= 1'b1;
        end else if (busy) begin
            part_r[idx_r*K +: K] <= grp_s;
            cy_r                 <= grp_co;
            idx_r                <= idx_r + 1'b1;
            if (fin) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spec_adder.sv
// Two-stage adder: decide stage (operands + mode registered), then add
// stage (speculative sum in one cycle, or the ripple engine).
module spec_adder
    import spadd_pkg::*;
#(
    parameter int unsigned N = 32,
    parameter int unsigned K = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [N-1:0] in_a,
    input  logic [N-1:0] in_b,
    output logic         out_done,
    output logic [N-1:0] out_sum,
    output logic         out_cout,
    output logic         out_slow
);
    add_mode_e    det_mode;
    logic         s1_valid;
    logic [N-1:0] s1_a, s1_b;
    add_mode_e    s1_mode;
    logic         s1_ext;
    logic         accept;

    logic [N-1:0] spec_sum;
    logic         spec_cout;

    logic         eng_busy, eng_fin, eng_cout;
    logic [N-1:0] eng_sum;

    // decide stage
    spadd_mode_detect #(.N(N), .K(K)) u_detect (
        .op_a (in_a[N-K-1:0]),
        .op_b (in_b[N-K-1:0]),
        .mode (det_mode)
    );

    assign s1_ext   = s1_valid && (s1_mode == MODE_EXT);
    assign in_ready = !eng_busy && !s1_ext;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_mode  <= MODE_FAST;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_a    <= in_a;
                s1_b    <= in_b;
                s1_mode <= det_mode;
            end
        end
    end

    // add stage
    spadd_spec_sum #(.N(N), .K(K)) u_spec (
        .a    (s1_a),
        .b    (s1_b),
        .sum  (spec_sum),
        .cout (spec_cout)
    );

    spadd_ext_engine #(.N(N), .K(K)) u_ext (
        .clk      (clk),
        .rst      (rst),
        .start    (s1_ext),
        .st_a     (s1_a),
        .st_b     (s1_b),
        .busy     (eng_busy),
        .fin      (eng_fin),
        .fin_sum  (eng_sum),
        .fin_cout (eng_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_done <= 1'b0;
            out_sum  <= '0;
            out_cout <= 1'b0;
            out_slow <= 1'b0;
        end else begin
            out_done <= 1'b0;
            if (eng_fin) begin
                out_done <= 1'b1;
                out_sum  <= eng_sum;
                out_cout <= eng_cout;
                out_slow <= 1'b1;
            end else if (s1_valid && !s1_ext) begin
                out_done <= 1'b1;
                out_sum  <= spec_sum;
                out_cout <= spec_cout;
                out_slow <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spadd_chk.sv
module spadd_chk #(
    parameter int unsigned N = 32,
    parameter int unsigned K = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_done,
    input logic [N-1:0] out_sum,
    input logic         out_cout,
    input logic         out_slow,
    input logic         s1_valid,
    input logic         s1_ext,
    input logic [N-1:0] s1_a,
    input logic [N-1:0] s1_b,
    input logic         eng_busy
);
    // R1
    fast_sum_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid && !s1_ext |=> {out_cout, out_sum} == ({1'b0, $past(s1_a)} + {1'b0, $past(s1_b)}));

    // R2
    fast_lat_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid && !s1_ext |=> out_done && !out_slow);

    // R5
    ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        s1_ext |=> !in_ready);

    // R5
    ready_back_chk: assert property (@(posedge clk) disable iff (rst)
        out_done && out_slow |-> in_ready);

    // R7
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> s1_valid);

    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid && !eng_busy |=> !out_done);

endmodule

bind spec_adder spadd_chk #(.N(N), .K(K)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_done (out_done),
    .out_sum  (out_sum),
    .out_cout (out_cout),
    .out_slow (out_slow),
    .s1_valid (s1_valid),
    .s1_ext   (s1_ext),
    .s1_a     (s1_a),
    .s1_b     (s1_b),
    .eng_busy (eng_busy)
);

// File: tb/spec_adder_bench.sv
`timescale 1ns/1ps
module spec_adder_bench;
    localparam int unsigned N = 32;
    localparam int unsigned K = 8;
    localparam int unsigned G = N / K;
    localparam int NV = 12;

    // {a, b, expected slow flag}
    localparam logic [64:0] VEC [NV] = '{
        {32'h00000003, 32'h00000004, 1'b0},
        {32'hFFFFFFFF, 32'h00000001, 1'b1},
        {32'h0000FF80, 32'h00000080, 1'b1},
        {32'hFF000000, 32'h00FFFF00, 1'b0},
        {32'h00FF8000, 32'h00008000, 1'b1},
        {32'hFF800000, 32'h00800000, 1'b0},
        {32'h000000FF, 32'h00000001, 1'b0},
        {32'h7FFFFFFF, 32'h00000001, 1'b1},
        {32'h80000000, 32'h80000000, 1'b0},
        {32'h00FFFFFF, 32'h00000001, 1'b1},
        {32'hFFFF0000, 32'h0000FFFF, 1'b0},
        {32'h00000000, 32'h00000000, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [N-1:0] in_a = '0;
    logic [N-1:0] in_b = '0;
    logic         out_done;
    logic [N-1:0] out_sum;
    logic         out_cout;
    logic         out_slow;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    int waits;
    logic [N+1:0] exp_q [$];   // {slow, cout, sum}

    always #4 clk = ~clk;

    spec_adder #(.N(N), .K(K)) u_spec_adder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_done(out_done), .out_sum(out_sum),
        .out_cout(out_cout), .out_slow(out_slow)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic ref_slow(input logic [N-1:0] a, input logic [N-1:0] b);
        logic c = 1'b0;
        logic [G-1:0] gin = '0;
        logic [N-1:0] x = a ^ b;
        logic s = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (i % K == 0) gin[i / K] = c;
            c = (a[i] & b[i]) | (x[i] & c);
        end
        for (int m = 1; m <= G - 2; m++) begin
            if (gin[m] && (&x[m*K +: K])) s = 1'b1;
        end
        return s;
    endfunction

    // result monitor: R1 sum/carry, R3 mode flag, R9 no stray done
    always @(negedge clk) begin
        if (!rst && out_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 stray done", 64'(out_sum), 64'h0);
            end else begin
                logic [N+1:0] e;
                e = exp_q.pop_front();
                chk({out_cout, out_sum} == e[N:0], "R1 sum", 64'({out_cout, out_sum}), 64'(e[N:0]));
                chk(out_slow == e[N+1], "R3 mode", 64'(out_slow), 64'(e[N+1]));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // call right after a negedge; returns right after the negedge following acceptance
    task automatic send(input logic [N-1:0] a, input logic [N-1:0] b, input logic slow);
        logic [N:0] full;
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        while (!in_ready) begin
            waits++;
            @(negedge clk);
        end
        full = {1'b0, a} + {1'b0, b};
        exp_q.push_back({slow, full});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] ra, rb;
        // R8: reset state
        repeat (2) @(negedge clk);
        chk(out_done == 1'b0, "R8 done", 64'(out_done), 64'h0);
        chk(in_ready == 1'b1, "R8 ready", 64'(in_ready), 64'h1);
        chk(out_sum == '0 && out_cout == 1'b0 && out_slow == 1'b0, "R8 outs",
            64'({out_slow, out_cout, out_sum}), 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // table walk (R1, R3, R6)
        for (int i = 0; i < NV; i++) begin
            logic [N-1:0] ta, tb;
            ta = VEC[i][64:33];
            tb = VEC[i][32:1];
            chk(ref_slow(ta, tb) == VEC[i][0], "R3 model", 64'(ref_slow(ta, tb)), 64'(VEC[i][0]));
            send(ta, tb, VEC[i][0]);
        end
        drain();

        // R6: top group propagating with carry from below stays fast, carry reaches cout
        send(32'hFF800000, 32'h00800000, 1'b0);
        @(negedge clk);
        chk(out_done && !out_slow && out_cout, "R6 top carry", 64'({out_done, out_slow, out_cout}), 64'h5);
        drain();

        // R2: fast latency
        send(32'h00001234, 32'h00004321, 1'b0);
        chk(out_done == 1'b0, "R2 early", 64'(out_done), 64'h0);
        @(negedge clk);
        chk(out_done == 1'b1, "R2 latency", 64'(out_done), 64'h1);
        drain();

        // R4 and R5: slow latency and ready
        send(32'hFFFFFFFF, 32'h00000001, 1'b1);
        for (int k = 1; k <= int'(G); k++) begin
            chk(in_ready == 1'b0, "R5 ready low", 64'(in_ready), 64'h0);
            chk(out_done == 1'b0, "R4 early", 64'(out_done), 64'h0);
            @(negedge clk);
        end
        chk(out_done == 1'b1 && out_slow == 1'b1, "R4 latency", 64'({out_done, out_slow}), 64'h3);
        chk(in_ready == 1'b1, "R5 ready back", 64'(in_ready), 64'h1);
        drain();

        // R7: back-to-back fast stream
        waits = 0;
        for (int i = 0; i < 8; i++) begin
            send(32'(i * 3), 32'(i + 100), 1'b0);
        end
        chk(waits == 0, "R7 no stall", 64'(waits), 64'h0);
        drain();

        // random, biased toward long propagate runs
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            if (i % 2 == 0) rb = ~ra ^ ($urandom & $urandom & $urandom);
            else            rb = $urandom;
            send(ra, rb, ref_slow(ra, rb));
        end
        drain();

        // R8: reset during a slow add drops it
        send(32'h0000FF80, 32'h00000080, 1'b1);
        rst = 1'b1;
        exp_q.delete();
        @(negedge clk);
        chk(out_done == 1'b0 && out_sum == '0, "R8 mid reset", 64'({out_done, out_sum}), 64'h0);
        chk(in_ready == 1'b1, "R8 ready", 64'(in_ready), 64'h1);
        rst = 1'b0;
        // R9: idle cycles give no done
        repeat (6) @(negedge clk);
        chk(out_done == 1'b0, "R9 idle", 64'(out_done), 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule